// File: doc/BRIEF.md
# Parallel Flash Program/Erase Sequencer

This block sits on the host side of a byte-wide parallel flash device. It takes one request at a time: a byte program, a sector erase, a block erase or a whole-chip erase. For each request it drives the unlock write sequence the device expects on its bus. It then polls the target location until the device reports that its internal operation has finished, and checks the byte it reads back. The result comes back as a one-cycle `done` pulse, with `error` raised in the same cycle when the operation failed.

The request side is a valid/ready handshake. A request moves when `req_valid` and `req_ready` are both high on a clock edge. `req_ready` is high only while the block is idle, so the requester must hold `req_valid` and the request fields steady until the handshake completes. The bus side uses a single access engine. Every write or read holds its strobe for a fixed number of clocks, with address and write data steady for the whole access, and the read byte is taken on the last strobe cycle.

Completion is judged on bit 6 of the polled byte, which the device toggles on every read while it is busy. A pair of reads that agree on bit 6 only marks the operation as finished tentatively. Two further reads must then agree, which guards against a read that coincided with the device finishing. A bound on the number of status reads turns a device that never finishes into an error.

Top module: `flash_op_sequencer`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A request is taken on an edge with `req_valid` and `req_ready` both high, and `busy` is high from the next cycle until the `done` cycle inclusive. While busy, `req_ready` stays low and any `req_valid` has no effect on the bus writes.
- R2: A program (`req_op`=0) writes, in this order: 0xAA to 0xAAA, 0x55 to 0x555, 0xA0 to 0xAAA, then `req_data` to `req_addr`. Command addresses are zero above bit 11.
- R3: Every erase writes 0xAA@0xAAA, 0x55@0x555, 0x80@0xAAA, 0xAA@0xAAA, 0x55@0x555. The sixth write is then 0x50 at the sector address for a sector erase (`req_op`=1), 0x30 at the block address for a block erase (`req_op`=2), or 0x10 at 0xAAA for a chip erase (`req_op`=3).
- R4: A sector erase clears the low SECT_AW address bits and a block erase clears the low BLK_AW bits, both for the sixth write and for polling. Program and chip erase poll at `req_addr` unchanged.
- R5: Each bus access holds exactly one strobe (`bus_we` or `bus_re`) high for ACC_CLKS cycles, with `bus_addr` and `bus_wdata` stable, followed by at least one cycle with both strobes low. The two strobes are never high together.
- R6: After the last write, the block reads the poll address repeatedly. Two successive reads with equal bit 6 mark the operation as tentatively finished.
- R7: A tentative finish is accepted only after two more reads that are bytewise identical to each other and keep the same bit 6. Otherwise polling resumes, and the final check uses the last confirming read.
- R8: For a program, `error` is raised when the accepted byte differs from `req_data`.
- R9: For any erase, `error` is raised when the accepted byte is not 0xFF.
- R10: When MAX_POLLS status reads pass without an accepted finish, the block stops reading and completes with `error` set; it issues exactly MAX_POLLS reads.
- R11: `done` is high for one cycle, and `error` is meaningful only in that cycle. In the next cycle `req_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this edge if valid |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | AW | Target byte address |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Failure flag, valid with `done` |
| bus_addr | output | AW | Flash address |
| bus_wdata | output | 8 | Flash write data |
| bus_rdata | input | 8 | Flash read data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |

## Verification
The embedded assertions assume that the request fields stay put while `req_valid` is high. They also assume that `bus_rdata` holds still during the strobe cycles of a read, because only the last of those cycles is sampled. The bench drives requests on the falling clock edge and holds them until the handshake edge. Its flash model moves to the next value only after a read strobe has dropped, so each read sees a single settled byte. The model toggles bit 6 for a chosen number of reads before it presents the final byte, and it can put a disturbed byte exactly on the second read of the bit-6 match or on the second confirming read.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  localparam logic [11:0] CMD_ADDR_HI = 12'hAAA;
  localparam logic [11:0] CMD_ADDR_LO = 12'h555;
  localparam logic [7:0]  ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/fseq_cmd_gen.sv
module fseq_cmd_gen
  import fseq_pkg::*;
#(
  parameter int AW      = 21,
  parameter int SECT_AW = 12,
  parameter int BLK_AW  = 16
) (
  input  op_e           op,
  input  logic [2:0]    step,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    data,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [2:0]    last_step,
  output logic [AW-1:0] tgt_addr
);
  localparam logic [AW-1:0] SECT_MASK = {AW{1'b1}} << SECT_AW;
  localparam logic [AW-1:0] BLK_MASK  = {AW{1'b1}} << BLK_AW;
  localparam logic [AW-1:0] A_HI = {{(AW-12){1'b0}}, CMD_ADDR_HI};
  localparam logic [AW-1:0] A_LO = {{(AW-12){1'b0}}, CMD_ADDR_LO};

  always_comb begin
    unique case (op)
      OP_SECT: tgt_addr = addr & SECT_MASK;
      OP_BLK:  tgt_addr = addr & BLK_MASK;
      default: tgt_addr = addr;
    endcase
  end

  always_comb begin
    last_step = (op == OP_PROG) ? 3'd3 : 3'd5;
    wr_addr   = A_HI;
    wr_data   = 8'hAA;
    case (step)
      3'd0: begin wr_addr = A_HI; wr_data = 8'hAA; end
      3'd1: begin wr_addr = A_LO; wr_data = 8'h55; end
      3'd2: begin wr_addr = A_HI; wr_data = (op == OP_PROG) ? 8'hA0 : 8'h80; end
      3'd3: begin
        if (op == OP_PROG) begin wr_addr = tgt_addr; wr_data = data; end
        else begin wr_addr = A_HI; wr_data = 8'hAA; end
      end
      3'd4: begin wr_addr = A_LO; wr_data = 8'h55; end
      default: begin
        unique case (op)
          OP_SECT: begin wr_addr = tgt_addr; wr_data = 8'h50; end
          OP_BLK:  begin wr_addr = tgt_addr; wr_data = 8'h30; end
          default: begin wr_addr = A_HI;     wr_data = 8'h10; end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/fseq_bus_timer.sv
module fseq_bus_timer #(
  parameter int ACC_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_read,
  output logic idle,
  output logic we,
  output logic re,
  output logic sample,
  output logic fin
);
  localparam int CW = $clog2(ACC_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(ACC_CLKS - 1);
  localparam logic [CW-1:0] GAP  = CW'(ACC_CLKS);

  logic          active, rd;
  logic [CW-1:0] cnt;
  logic          strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      rd     <= 1'b0;
      cnt    <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        rd     <= is_read;
        cnt    <= '0;
      end
    end else if (cnt == GAP) begin
      active <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign strobe = active && (cnt < GAP);
  assign idle   = !active;
  assign we     = strobe && !rd;
  assign re     = strobe && rd;
  assign sample = re && (cnt == LAST);
  assign fin    = active && (cnt == GAP);

  assert_gap_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !we && !re);
endmodule

// File: rtl/fseq_poll_judge.sv
module fseq_poll_judge #(
  parameter int MAX_POLLS = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       sample,
  input  logic [7:0] rdata,
  output logic       settled,
  output logic       expired,
  output logic [7:0] final_byte
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST_READ = CW'(MAX_POLLS - 1);

  typedef enum logic [1:0] {J_SEEK, J_TRACK, J_CONF1, J_CONF2} jph_e;

  jph_e          ph;
  logic [7:0]    prev, conf1;
  logic [CW-1:0] nreads;
  logic          accept_now, take;

  assign take       = sample && !settled && !expired;
  assign accept_now = take && (ph == J_CONF2) && (rdata == conf1) && (rdata[6] == prev[6]);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      ph         <= J_SEEK;
      prev       <= '0;
      conf1      <= '0;
      nreads     <= '0;
      settled    <= 1'b0;
      expired    <= 1'b0;
      final_byte <= '0;
    end else if (take) begin
      nreads <= nreads + 1'b1;
      unique case (ph)
        J_SEEK:  begin prev <= rdata; ph <= J_TRACK; end
        J_TRACK: begin
          if (rdata[6] == prev[6]) ph <= J_CONF1;
          prev <= rdata;
        end
        J_CONF1: begin conf1 <= rdata; ph <= J_CONF2; end
        J_CONF2: begin
          if (!accept_now) begin prev <= rdata; ph <= J_TRACK; end
        end
      endcase
      if (accept_now) begin
        settled    <= 1'b1;
        final_byte <= rdata;
      end else if (nreads == LAST_READ) begin
        expired <= 1'b1;
      end
    end
  end

  assert_read_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    nreads <= CW'(MAX_POLLS));
  assert_verdict_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(settled && expired));
  assert_accept_after_confirm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled) |-> $past(ph) == J_CONF2);
endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer
  import fseq_pkg::*;
#(
  parameter int AW        = 21,
  parameter int SECT_AW   = 12,
  parameter int BLK_AW    = 16,
  parameter int ACC_CLKS  = 3,
  parameter int MAX_POLLS = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata,
  output logic          bus_we,
  output logic          bus_re
);
  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_POLL, S_FIN} st_e;

  st_e           state;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [2:0]    step_q;
  logic          err_q;

  logic [AW-1:0] wr_addr, tgt_addr;
  logic [7:0]    wr_data, final_byte, expect_byte;
  logic [2:0]    last_step;
  logic          tmr_idle, tmr_sample, tmr_fin, tmr_start;
  logic          settled, expired, accept;

  assign accept    = req_valid && req_ready;
  assign tmr_start = (state == S_WRITE || state == S_POLL) && tmr_idle;

  fseq_cmd_gen #(.AW(AW), .SECT_AW(SECT_AW), .BLK_AW(BLK_AW)) u_cmd (
    .op(op_q), .step(step_q), .addr(addr_q), .data(data_q),
    .wr_addr(wr_addr), .wr_data(wr_data), .last_step(last_step), .tgt_addr(tgt_addr)
  );

  fseq_bus_timer #(.ACC_CLKS(ACC_CLKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .is_read(state == S_POLL),
    .idle(tmr_idle), .we(bus_we), .re(bus_re), .sample(tmr_sample), .fin(tmr_fin)
  );

  fseq_poll_judge #(.MAX_POLLS(MAX_POLLS)) u_judge (
    .clk(clk), .rst_n(rst_n), .clear(accept), .sample(tmr_sample), .rdata(bus_rdata),
    .settled(settled), .expired(expired), .final_byte(final_byte)
  );

  assign expect_byte = (op_q == OP_PROG) ? data_q : ERASED_BYTE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
      step_q <= '0;
      err_q  <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          op_q   <= op_e'(req_op);
          addr_q <= req_addr;
          data_q <= req_data;
          step_q <= '0;
          err_q  <= 1'b0;
          state  <= S_WRITE;
        end
        S_WRITE: if (tmr_fin) begin
          if (step_q == last_step) state <= S_POLL;
          else step_q <= step_q + 1'b1;
        end
        S_POLL: if (tmr_fin) begin
          if (settled) begin
            err_q <= (final_byte != expect_byte);
            state <= S_FIN;
          end else if (expired) begin
            err_q <= 1'b1;
            state <= S_FIN;
          end
        end
        S_FIN: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);
  assign error     = done && err_q;
  assign bus_addr  = (state == S_WRITE) ? wr_addr : (state == S_POLL) ? tgt_addr : '0;
  assign bus_wdata = (state == S_WRITE) ? wr_data : 8'h00;

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));
  assert_we_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && $past(bus_we)) |-> $stable(bus_addr) && $stable(bus_wdata));
  assert_re_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && $past(bus_re)) |-> $stable(bus_addr));
  assert_take_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && !req_ready);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);
  assert_no_strobe_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_we && !bus_re);
endmodule

// File: tb/flash_op_sequencer_bench.sv
module flash_op_sequencer_bench;
  localparam int AW = 16, SECT_AW = 12, BLK_AW = 14, ACC = 3, MAXP = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, busy, done, error, bus_we, bus_re;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0, bus_addr;
  logic [7:0] req_data = '0, bus_wdata, bus_rdata;

  always #5 clk = ~clk;

  flash_op_sequencer #(.AW(AW), .SECT_AW(SECT_AW), .BLK_AW(BLK_AW), .ACC_CLKS(ACC),
    .MAX_POLLS(MAXP)) u_flash_op_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done), .error(error),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_we(bus_we), .bus_re(bus_re));

  int compared = 0, mismatched = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flash model: busy for m_k reads (bit 6 toggles), then final byte
  int m_k = 1, m_idx = 0, m_g = 0;
  logic [7:0] m_fin = 8'hFF;
  logic [AW-1:0] m_paddr = '0;
  function automatic logic [7:0] model_byte(int i);
    if (i <= m_k) return {~m_fin[7], i[0], 6'b0};
    if (i == m_g) return m_fin ^ 8'h01;
    return m_fin;
  endfunction
  assign bus_rdata = model_byte(m_idx + 1);

  // bus monitor
  logic [AW-1:0] log_a[8];
  logic [7:0] log_d[8];
  int log_n = 0, we_len = 0, re_len = 0, bad_w = 0, bad_a = 0, reads = 0;
  logic we_q = 1'b0, re_q = 1'b0;
  always @(posedge clk) begin
    we_q <= bus_we;
    re_q <= bus_re;
    if (bus_we && bus_re) bad_w <= bad_w + 1;
    if (bus_we && !we_q && log_n < 8) begin
      log_a[log_n] <= bus_addr; log_d[log_n] <= bus_wdata; log_n <= log_n + 1;
    end
    if (bus_we) we_len <= we_len + 1;
    else begin if (we_q && we_len != ACC) bad_w <= bad_w + 1; we_len <= 0; end
    if (bus_re) re_len <= re_len + 1;
    else begin if (re_q && re_len != ACC) bad_w <= bad_w + 1; re_len <= 0; end
    if (bus_re && !re_q) begin
      reads <= reads + 1;
      if (bus_addr != m_paddr) bad_a <= bad_a + 1;
    end
    if (!bus_re && re_q) m_idx <= m_idx + 1;
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic logic [AW-1:0] tgt_of(logic [1:0] op, logic [AW-1:0] a);
    if (op == 2'd1) return a & ({AW{1'b1}} << SECT_AW);
    if (op == 2'd2) return a & ({AW{1'b1}} << BLK_AW);
    return a;
  endfunction

  function automatic int pair_second(int k, logic [7:0] fin);
    return (k[0] == fin[6]) ? k + 1 : k + 2;
  endfunction

  task automatic run_op(logic [1:0] op, logic [AW-1:0] a, logic [7:0] d, int k,
                        logic [7:0] fin, int glitch, logic exp_err, int exp_reads,
                        bit poke_busy);
    logic [AW-1:0] ea[6];
    logic [7:0] ed[6];
    int n;
    logic [AW-1:0] t;
    logic okw;
    string tag;
    t = tgt_of(op, a);
    ea[0] = 'hAAA; ed[0] = 8'hAA; ea[1] = 'h555; ed[1] = 8'h55;
    if (op == 2'd0) begin
      n = 4; ea[2] = 'hAAA; ed[2] = 8'hA0; ea[3] = t; ed[3] = d; tag = "R2";
    end else begin
      n = 6; ea[2] = 'hAAA; ed[2] = 8'h80; ea[3] = 'hAAA; ed[3] = 8'hAA;
      ea[4] = 'h555; ed[4] = 8'h55;
      ea[5] = (op == 2'd3) ? AW'('hAAA) : t;
      ed[5] = (op == 2'd1) ? 8'h50 : (op == 2'd2) ? 8'h30 : 8'h10;
      tag = (op == 2'd3) ? "R3" : "R3/R4";
    end
    @(negedge clk);
    m_k = k; m_fin = fin; m_idx = 0; m_paddr = t;
    m_g = (glitch == 1) ? pair_second(k, fin) : (glitch == 2) ? pair_second(k, fin) + 2 : 0;
    log_n = 0; reads = 0; bad_w = 0; bad_a = 0;
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 busy after take", busy, 1'b1);
    if (poke_busy) begin
      for (int i = 0; i < 5; i++) begin
        req_valid = 1'b1; req_op = 2'd3; req_addr = '1;
        @(negedge clk);
        check("R1 ready low while busy", req_ready, 1'b0);
      end
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    check(exp_err ? "R8/R9/R10 error expected" : "R8/R9 no error", error, exp_err);
    check("R5 strobe shape", bad_w, 0);
    check("R6 poll address", bad_a, 0);
    check({tag, " write count"}, log_n, n);
    okw = 1'b1;
    for (int i = 0; i < n; i++) if (log_a[i] != ea[i] || log_d[i] != ed[i]) okw = 1'b0;
    check({tag, " write sequence"}, okw, 1'b1);
    if (exp_reads > 0) check("R6/R7/R10 read count", reads, exp_reads);
    @(negedge clk);
    check("R11 done one cycle", done, 1'b0);
    check("R11 ready after done", req_ready, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset ready", req_ready, 1'b1);
    check("R1 reset busy", busy, 1'b0);
    check("R11 reset done", done, 1'b0);
    check("R5 reset strobes", {bus_we, bus_re}, 2'b00);
    rst_n = 1'b1;
    // directed corners
    run_op(2'd0, 16'h1234, 8'h5A, 3, 8'h5A, 0, 1'b0, 0, 1'b1);   // R1 poke while busy
    run_op(2'd1, 16'hBEEF, 8'h00, 2, 8'hFF, 0, 1'b0, 0, 1'b0);   // R4 sector
    run_op(2'd2, 16'hBEEF, 8'h00, 4, 8'hFF, 0, 1'b0, 0, 1'b0);   // R4 block
    run_op(2'd3, 16'h0777, 8'h00, 1, 8'hFF, 0, 1'b0, 0, 1'b0);   // R3 chip
    run_op(2'd0, 16'h0042, 8'h3C, 3, 8'h3D, 0, 1'b1, 0, 1'b0);   // R8 bad readback
    run_op(2'd1, 16'h2000, 8'h00, 2, 8'hEF, 0, 1'b1, 0, 1'b0);   // R9 bad erase
    run_op(2'd0, 16'h0100, 8'h77, 100, 8'h77, 0, 1'b1, MAXP, 1'b0); // R10 timeout
    // R7: disturbed byte on the matching read, then on the second confirm read
    run_op(2'd0, 16'h0200, 8'h81, 3, 8'h81, 1, 1'b0, pair_second(3, 8'h81) + 2, 1'b0);
    run_op(2'd0, 16'h0201, 8'hC4, 2, 8'hC4, 2, 1'b0, pair_second(2, 8'hC4) + 5, 1'b0);
    run_op(2'd2, 16'h7001, 8'h00, 5, 8'hFF, 2, 1'b0, pair_second(5, 8'hFF) + 5, 1'b0);
    // constrained random mix
    for (int r = 0; r < 24; r++) begin
      logic [1:0] op;
      logic [AW-1:0] a;
      logic [7:0] d, good, fin;
      int k, gl;
      bit bad;
      op = 2'($urandom_range(0, 3));
      a = AW'($urandom);
      d = 8'($urandom);
      k = $urandom_range(1, 6);
      gl = $urandom_range(0, 2);
      bad = ($urandom_range(0, 3) == 0);
      good = (op == 2'd0) ? d : 8'hFF;
      fin = bad ? (good ^ 8'h10) : good;
      run_op(op, a, d, k, fin, gl, bad, 0, 1'b0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule